// File: doc/BRIEF.md
# Codec Power-State and Output-Enable Controller

This block decides whether a PCM codec is awake or asleep, and it produces the enables for the codec's tri-stateable outputs. It watches three asynchronous inputs: an active-low sleep request pin, the transmit frame sync and the receive frame sync. There are two ways into the sleep state. The first is to pull the request pin low. The second is for both frame syncs to go quiet, which the block sees as an absence of rising edges on either sync for a fixed number of 256 kHz sequencing ticks. The ticks are made by dividing the master clock.

Waking up requires two things: the request pin must be high and a transmit frame-sync edge must arrive. Once awake, the general output enable turns on at once. The serial transmit data enable is held off until a set number of further transmit frame pulses have been counted. Because that counter restarts every time the block goes to sleep, each wake-up repeats the same quiet period on the data line. The block drives only enables; the bias circuits and the pad buffers sit outside it.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: After the synchronous active-low reset, the block is asleep: `pwr_down`=1, `out_en`=0 and `dt_en`=0.
- R2: While the sleep pin is low, the block goes asleep no later than the third clock edge after the pin falls (two synchronizer stages plus the state register). This holds whatever the frame syncs are doing.
- R3: While awake, if no rising edge is seen on either frame sync for TIMEOUT_TICKS ticks, the block goes asleep. One tick is TICK_DIV clocks.
- R4: A rising edge on the receive frame sync alone restarts the quiet-sync timeout. An awake block fed only receive pulses stays awake.
- R5: The block leaves sleep only on a transmit frame-sync rising edge while the sleep pin is high. Receive-sync edges alone, or a high pin with no transmit edges, leave it asleep.
- R6: While asleep, `out_en` and `dt_en` are both 0. While awake, `out_en` is 1.
- R7: The transmit edge that wakes the block is not counted. `dt_en` stays 0 until DT_FRAMES (default 2) further transmit rising edges have been seen, and rises after the last of them.
- R8: The transmit pulse count saturates at DT_FRAMES. Further pulses keep `dt_en` at 1.
- R9: Each entry into sleep clears the pulse count, so every later wake-up waits DT_FRAMES pulses again before `dt_en` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pdn_n_in | input | 1 | Asynchronous sleep request, low = sleep |
| fst_in | input | 1 | Asynchronous transmit frame sync |
| fsr_in | input | 1 | Asynchronous receive frame sync |
| pwr_down | output | 1 | High while the codec is asleep |
| out_en | output | 1 | Enable for the general tri-stateable outputs |
| dt_en | output | 1 | Enable for the serial transmit data output |

## Verification
The wake logic is first tried with receive pulses only and with a high pin but no transmit pulses. Both must leave the block asleep, which separates "any sync activity" from "transmit activity". Transmit-only pulses and receive-only pulses are then used while awake, to tell the data-enable counting apart from the liveness timeout, and full silence is used to fire the timeout. Finally, pulling the sleep pin low in the middle of a transmit pulse train checks that the pin overrides a live sync. The wake-up after it checks that the pulse count restarted.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
  localparam int SYN_PDN = 0;
  localparam int SYN_FST = 1;
  localparam int SYN_FSR = 2;
  localparam int SYN_NUM = 3;

  function automatic int unsigned sat_step(input int unsigned cur, input int unsigned lim);
    return (cur < lim) ? cur + 1 : lim;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/cpc_sync.sv
module cpc_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] stage1, stage2, prev;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage1[i] <= 1'b0;
        stage2[i] <= 1'b0;
        prev[i]   <= 1'b0;
      end else begin
        stage1[i] <= async_in[i];
        stage2[i] <= stage1[i];
        prev[i]   <= stage2[i];
      end
    end
    assign rise[i] = stage2[i] & ~prev[i];
  end

  assign level = stage2;
endmodule

// File: rtl/cpc_tick.sv
module cpc_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [W-1:0] LAST = W'(DIV - 1);
  logic [W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cpc_idle_watch.sv
module cpc_idle_watch
  import codec_pwr_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic activity,
  output logic lost
);
  localparam int W = cnt_width(TIMEOUT);
  localparam logic [W-1:0] LIMIT = W'(TIMEOUT);
  logic [W-1:0] quiet;

  assign lost = (quiet == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)        quiet <= LIMIT;
    else if (activity) quiet <= '0;
    else if (tick)     quiet <= W'(sat_step(int'(quiet), TIMEOUT));
  end
endmodule

// File: rtl/cpc_frame_gate.sv
module cpc_frame_gate
  import codec_pwr_pkg::*;
#(
  parameter int FRAMES = 2,
  localparam int W = cnt_width(FRAMES)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         pulse,
  output logic [W-1:0] count,
  output logic         reached
);
  localparam logic [W-1:0] GOAL = W'(FRAMES);

  assign reached = (count == GOAL);

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (pulse) count <= W'(sat_step(int'(count), FRAMES));
  end
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
  import codec_pwr_pkg::*;
#(
  parameter int TICK_DIV      = 8,
  parameter int TIMEOUT_TICKS = 64,
  parameter int DT_FRAMES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pdn_n_in,
  input  logic fst_in,
  input  logic fsr_in,
  output logic pwr_down,
  output logic out_en,
  output logic dt_en
);
  localparam int CW = cnt_width(DT_FRAMES);

  logic [SYN_NUM-1:0] pin_vec, lvl_vec, rise_vec;
  logic pdn_sync, fst_rise, fsr_rise, sync_lost, tick, frames_done, asleep;
  logic [CW-1:0] frame_cnt;

  assign pin_vec[SYN_PDN] = pdn_n_in;
  assign pin_vec[SYN_FST] = fst_in;
  assign pin_vec[SYN_FSR] = fsr_in;

  cpc_sync #(.WIDTH(SYN_NUM)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_vec), .level(lvl_vec), .rise(rise_vec)
  );

  assign pdn_sync = lvl_vec[SYN_PDN];
  assign fst_rise = rise_vec[SYN_FST];
  assign fsr_rise = rise_vec[SYN_FSR];

  cpc_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  cpc_idle_watch #(.TIMEOUT(TIMEOUT_TICKS)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(tick), .activity(fst_rise | fsr_rise), .lost(sync_lost)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         asleep <= 1'b1;
    else if (!pdn_sync) asleep <= 1'b1;
    else if (asleep) begin
      if (fst_rise) asleep <= 1'b0;
    end else if (sync_lost && !(fst_rise || fsr_rise)) begin
      asleep <= 1'b1;
    end
  end

  cpc_frame_gate #(.FRAMES(DT_FRAMES)) u_gate (
    .clk(clk), .rst_n(rst_n), .clear(asleep), .pulse(fst_rise),
    .count(frame_cnt), .reached(frames_done)
  );

  assign pwr_down = asleep;
  assign out_en   = ~asleep;
  assign dt_en    = ~asleep & frames_done;
endmodule

// File: rtl/codec_pwr_ctrl_chk.sv
module codec_pwr_ctrl_chk #(
  parameter int DT_FRAMES = 2,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_down,
  input logic          out_en,
  input logic          dt_en,
  input logic          pdn_sync,
  input logic          fst_rise,
  input logic          fsr_rise,
  input logic          sync_lost,
  input logic [CW-1:0] frame_cnt
);
  AST_PIN_FORCES_SLEEP: assert property (@(posedge clk) disable iff (!rst_n) !pdn_sync |=> pwr_down); // R2
  AST_QUIET_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n) (sync_lost && !fst_rise && !fsr_rise) |=> pwr_down); // R3
  AST_WAKE_NEEDS_FST: assert property (@(posedge clk) disable iff (!rst_n) $fell(pwr_down) |-> ($past(fst_rise) && $past(pdn_sync))); // R5
  AST_ASLEEP_DT_OFF: assert property (@(posedge clk) disable iff (!rst_n) pwr_down |-> !dt_en); // R6
  AST_DT_RISES_ON_FST: assert property (@(posedge clk) disable iff (!rst_n) $rose(dt_en) |-> ($past(fst_rise) && !$past(pwr_down))); // R7
  AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n) int'(frame_cnt) <= DT_FRAMES); // R8
  AST_SLEEP_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) $past(pwr_down) && pwr_down |-> frame_cnt == '0); // R9
endmodule

bind codec_pwr_ctrl codec_pwr_ctrl_chk #(.DT_FRAMES(DT_FRAMES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .out_en(out_en), .dt_en(dt_en),
  .pdn_sync(pdn_sync), .fst_rise(fst_rise), .fsr_rise(fsr_rise),
  .sync_lost(sync_lost), .frame_cnt(frame_cnt)
);

// File: tb/codec_pwr_ctrl_bench.sv
module codec_pwr_ctrl_bench;
  localparam int DIV = 8;
  localparam int TMO = 64;
  localparam int NFR = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pdn_n = 1'b0, fst = 1'b0, fsr = 1'b0;
  logic pwr_down, out_en, dt_en;
  int n_chk = 0, n_fail = 0, cyc = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  codec_pwr_ctrl #(.TICK_DIV(DIV), .TIMEOUT_TICKS(TMO), .DT_FRAMES(NFR)) u_codec_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .pdn_n_in(pdn_n), .fst_in(fst), .fsr_in(fsr),
    .pwr_down(pwr_down), .out_en(out_en), .dt_en(dt_en)
  );

  // Reference model: input history queue plus integer state
  logic [2:0] hist[$];
  int m_quiet, m_tick, m_frames;
  bit m_sleep;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      hist = {3'b000, 3'b000, 3'b000};
      m_quiet = TMO; m_tick = 0; m_frames = 0; m_sleep = 1;
    end else begin
      logic [2:0] old_p, old_s;
      bit f_up, r_up, pin_hi, quiet_out;
      old_p = hist[0]; old_s = hist[1];
      pin_hi = old_s[0];
      f_up = old_s[1] && !old_p[1];
      r_up = old_s[2] && !old_p[2];
      quiet_out = (m_quiet == TMO);
      if (m_sleep) m_frames = 0;
      else if (f_up && m_frames < NFR) m_frames++;
      if (!pin_hi) m_sleep = 1;
      else if (m_sleep) begin if (f_up) m_sleep = 0; end
      else if (quiet_out && !f_up && !r_up) m_sleep = 1;
      if (f_up || r_up) m_quiet = 0;
      else if (m_tick == DIV - 1 && m_quiet < TMO) m_quiet++;
      m_tick = (m_tick == DIV - 1) ? 0 : m_tick + 1;
      void'(hist.pop_front());
      hist.push_back({fsr, fst, pdn_n});
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cyc > 1 && !done) begin
      check(phase, "model pwr_down", pwr_down, m_sleep);
      check(phase, "model out_en", out_en, !m_sleep);
      check(phase, "model dt_en", dt_en, !m_sleep && m_frames == NFR);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic fst_pulse(int gap);
    fst = 1'b1; step(4); fst = 1'b0; step(gap);
  endtask

  task automatic fsr_pulse(int gap);
    fsr = 1'b1; step(4); fsr = 1'b0; step(gap);
  endtask

  task automatic now(string req, string what, logic act, logic exp);
    @(negedge clk);
    check(req, what, act, exp);
    step(0);
  endtask

  initial begin
    step(5);
    now("R1", "pwr_down after reset", pwr_down, 1'b1);
    now("R1", "out_en after reset", out_en, 1'b0);
    now("R1", "dt_en after reset", dt_en, 1'b0);
    rst_n = 1'b1;
    phase = "R5";
    pdn_n = 1'b1; step(30);
    now("R5", "pin high, no FST, still asleep", pwr_down, 1'b1);
    for (int i = 0; i < 4; i++) fsr_pulse(30);
    now("R5", "FSR only, still asleep", pwr_down, 1'b1);
    now("R6", "asleep out_en", out_en, 1'b0);
    phase = "R7";
    fst_pulse(30);
    now("R5", "FST edge wakes", pwr_down, 1'b0);
    now("R6", "awake out_en", out_en, 1'b1);
    now("R7", "dt_en after wake pulse", dt_en, 1'b0);
    fst_pulse(30);
    now("R7", "dt_en after one more pulse", dt_en, 1'b0);
    fst_pulse(30);
    now("R7", "dt_en after two more pulses", dt_en, 1'b1);
    phase = "R8";
    for (int i = 0; i < 4; i++) fst_pulse(30);
    now("R8", "dt_en stays high", dt_en, 1'b1);
    phase = "R4";
    for (int i = 0; i < 25; i++) fsr_pulse(36);
    now("R4", "FSR only keeps awake", pwr_down, 1'b0);
    now("R4", "dt_en kept", dt_en, 1'b1);
    phase = "R3";
    step(400);
    now("R3", "before timeout still awake", pwr_down, 1'b0);
    step(200);
    now("R3", "quiet timeout sleeps", pwr_down, 1'b1);
    now("R6", "dt_en off asleep", dt_en, 1'b0);
    phase = "R9";
    fst_pulse(30);
    now("R9", "rewake", pwr_down, 1'b0);
    fst_pulse(30);
    now("R9", "count restarted, dt_en low", dt_en, 1'b0);
    fst_pulse(30);
    now("R9", "dt_en after two pulses", dt_en, 1'b1);
    phase = "R2";
    fst = 1'b1; step(1);
    pdn_n = 1'b0;
    step(3);
    now("R2", "pin low sleeps within 3 edges", pwr_down, 1'b1);
    fst = 1'b0; step(20);
    for (int i = 0; i < 3; i++) fst_pulse(30);
    now("R2", "pin low overrides FST", pwr_down, 1'b1);
    now("R6", "out_en off", out_en, 1'b0);
    now("R6", "dt_en off", dt_en, 1'b0);
    phase = "R9";
    pdn_n = 1'b1; step(10);
    fst_pulse(30);
    now("R5", "pin high plus FST wakes", pwr_down, 1'b0);
    fst_pulse(30);
    now("R9", "after pin sleep, dt_en low", dt_en, 1'b0);
    fst_pulse(30);
    now("R9", "after pin sleep, dt_en high", dt_en, 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule